// File: doc/BRIEF.md
# Byte-Committing Three-Wire Serial Control Register

This block is a receive-only serial slave that loads a 16-bit control word from a host. It has three wires: an active-low select, a serial clock and a data line. While select is low, the block takes one data bit on each rising edge of the serial clock, most significant bit first. The block does not wait for the end of the frame. Each time a byte's worth of bits has arrived, that byte is written straight into its half of the control register. A host can therefore retune only the upper half by sending eight bits and then deasserting select.

The three pins are synchronised into one fast system clock, and serial-clock edges are detected in that domain. The committed word is presented as three decoded fields:

- a 4-bit octave code from word bits 15..12;
- a 10-bit fine code from bits 11..2;
- a 2-bit output configuration from bits 1..0.

A one-cycle strobe marks every byte commit, with a flag that says which half was written.

Top module: `sctl_port`

## Requirements
- R1: After reset the octave, fine and configuration outputs are all zero and the update strobe is low.
- R2: A 16-bit frame is taken MSB first, so its first bit becomes word bit 15. Octave is word[15:12], fine is word[11:2] and configuration is word[1:0].
- R3: On the 8th rising serial-clock edge of a transaction, the 8 bits received so far are written to word[15:8]. word[7:0] is unchanged, and the strobe is raised with upd_upper = 1.
- R4: On the 16th rising edge, the last 8 bits are written to word[7:0]. word[15:8] is unchanged, and the strobe is raised with upd_upper = 0.
- R5: A commit appears on the outputs, and the strobe is high, in the system-clock cycle that ends exactly SYNC_STAGES+1 system-clock rising edges after the serial-clock rise. With the default of 2 stages, that is 3 edges.
- R6: Serial-clock edges that arrive while select is high change no output and raise no strobe.
- R7: If select rises before a byte is complete, that partial byte is discarded and no register bit changes. The next transaction starts again at word bit 15.
- R8: Edges after the 16th in one transaction are ignored. A long transaction gives exactly two strobes, and the register keeps the first 16 bits.
- R9: The strobe is high for one system-clock cycle per committed byte, and the register changes only in a cycle where the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| sdi | input | 1 | Serial data in |
| octave | output | OCT_W (4) | Octave code, word[15:12] |
| fine | output | FINE_W (10) | Fine code, word[11:2] |
| out_cfg | output | CFG_W (2) | Output configuration, word[1:0] |
| upd_stb | output | 1 | One-cycle pulse per committed byte |
| upd_upper | output | 1 | With upd_stb: 1 = upper byte written, 0 = lower byte |

## Verification
Every committed byte is due on the fields and the strobe exactly three system-clock rising edges after the falling clock edge at which the bench raises the serial clock. This is two synchroniser stages plus the edge-detect and commit register. The bench drives all pins at falling edges. When it drives the 8th or 16th bit of a transaction, it queues the expected word and half flag with that due cycle. At every falling edge it compares fields, strobe and flag against the queue, so a commit that is early, late, doubled or missing is caught in the cycle it occurs. Field checks after each transaction confirm the ignore, discard and overrun cases.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

   // Default geometry of the control word
   localparam int unsigned SCTL_OCT_W  = 4;
   localparam int unsigned SCTL_FINE_W = 10;
   localparam int unsigned SCTL_CFG_W  = 2;
   localparam int unsigned SCTL_BYTE_W = 8;
   localparam int unsigned SCTL_SYNC   = 2;

   // Least significant bit of a byte lane; lane 0 is the first byte on the wire
   function automatic int unsigned lane_lsb(int unsigned lane,
                                            int unsigned word_w,
                                            int unsigned byte_w);
      return word_w - (lane + 1) * byte_w;
   endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int unsigned        STAGES  = 2,
   parameter int unsigned        W       = 3,
   parameter logic [W-1:0]       RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES == 0) begin : g_bypass
      // Inputs already synchronous to clk
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q[s] <= RST_VAL;
            else if (s == 0) stage_q[s] <= d;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
         end
      end

      assign q = stage_q[STAGES-1];
   end

endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NBYTES = WORD_W / BYTE_W,
   localparam int unsigned CNT_W  = $clog2(WORD_W + 1),
   localparam int unsigned IDX_W  = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   output logic              commit_req,
   output logic [IDX_W-1:0]  commit_idx,
   output logic [BYTE_W-1:0] commit_data
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   logic              sclk_prev;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] acc;
   logic              rise;
   logic              take;
   logic [CNT_W-1:0]  slot;

   // Rising edge of the synchronised serial clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   always_comb begin
      rise = sclk_s & ~sclk_prev;
      take = rise & ~en_n_s & (bit_cnt != CNT_FULL);
      slot = bit_cnt % CNT_BYTE;
   end

   // Bit counter and partial byte; cleared whenever select is high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         acc     <= '0;
      end else if (en_n_s) begin
         bit_cnt <= '0;
         acc     <= '0;
      end else if (take) begin
         bit_cnt <= bit_cnt + 1'b1;
         acc     <= {acc[BYTE_W-3:0], sdi_s};
      end
   end

   // The completing bit is taken straight from the pin, so the byte commits on its own edge
   always_comb begin
      commit_req  = take && (slot == CNT_LAST);
      commit_idx  = IDX_W'(bit_cnt / CNT_BYTE);
      commit_data = {acc, sdi_s};
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_FULL);  // R8

   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      en_n_s |=> (bit_cnt == '0));  // R7

endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
   import sctl_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NBYTES = WORD_W / BYTE_W,
   localparam int unsigned IDX_W  = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_req,
   input  logic [IDX_W-1:0]  commit_idx,
   input  logic [BYTE_W-1:0] commit_data,
   output logic [WORD_W-1:0] word_o,
   output logic              stb_o,
   output logic              upper_o
);

   logic [BYTE_W-1:0] lane_q [NBYTES];
   logic              stb_q;
   logic              upper_q;

   for (genvar l = 0; l < NBYTES; l++) begin : g_lane
      localparam int unsigned LSB = lane_lsb(l, WORD_W, BYTE_W);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q[l] <= '0;  // R1
         else if (commit_req && (commit_idx == IDX_W'(l)))
            lane_q[l] <= commit_data;
      end

      assign word_o[LSB +: BYTE_W] = lane_q[l];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q   <= 1'b0;
         upper_q <= 1'b0;
      end else begin
         stb_q <= commit_req;
         if (commit_req) upper_q <= (commit_idx == '0);
      end
   end

   assign stb_o   = stb_q;
   assign upper_o = upper_q;

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_q |-> $stable(word_o));  // R6

   AST_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_q && upper_q) |-> $stable(word_o[WORD_W-BYTE_W-1:0]));  // R3

   AST_LOWER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_q && !upper_q) |-> $stable(word_o[WORD_W-1 -: BYTE_W]));  // R4

   AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |=> !stb_q);  // R9

endmodule

// File: rtl/sctl_port.sv
module sctl_port
   import sctl_pkg::*;
#(
   parameter int unsigned OCT_W       = SCTL_OCT_W,
   parameter int unsigned FINE_W      = SCTL_FINE_W,
   parameter int unsigned CFG_W       = SCTL_CFG_W,
   parameter int unsigned BYTE_W      = SCTL_BYTE_W,
   parameter int unsigned SYNC_STAGES = SCTL_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sen_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic [OCT_W-1:0]  octave,
   output logic [FINE_W-1:0] fine,
   output logic [CFG_W-1:0]  out_cfg,
   output logic              upd_stb,
   output logic              upd_upper
);

   localparam int unsigned WORD_W = OCT_W + FINE_W + CFG_W;
   localparam int unsigned NBYTES = WORD_W / BYTE_W;
   localparam int unsigned IDX_W  = $clog2(NBYTES);

   if (WORD_W % BYTE_W != 0) begin : g_err_lanes
      $error("control word width must be a whole number of bytes");
   end
   if (NBYTES < 2) begin : g_err_nbytes
      $error("control word must span at least two bytes");
   end
   if (BYTE_W < 4) begin : g_err_byte
      $error("byte width must be at least 4");
   end
   if (SYNC_STAGES == 1) begin : g_err_sync
      $error("use 0 stages for synchronous pins or at least 2 for asynchronous ones");
   end

   logic [2:0]        pins_s;
   logic              en_n_s;
   logic              sclk_s;
   logic              sdi_s;
   logic              commit_req;
   logic [IDX_W-1:0]  commit_idx;
   logic [BYTE_W-1:0] commit_data;
   logic [WORD_W-1:0] word;

   // Select idles high, so it resets to 1
   sctl_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (3),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sen_n, sclk, sdi}),
      .q     (pins_s)
   );

   assign {en_n_s, sclk_s, sdi_s} = pins_s;

   sctl_shift #(
      .WORD_W (WORD_W),
      .BYTE_W (BYTE_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_n_s      (en_n_s),
      .sclk_s      (sclk_s),
      .sdi_s       (sdi_s),
      .commit_req  (commit_req),
      .commit_idx  (commit_idx),
      .commit_data (commit_data)
   );

   sctl_regfile #(
      .WORD_W (WORD_W),
      .BYTE_W (BYTE_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_req  (commit_req),
      .commit_idx  (commit_idx),
      .commit_data (commit_data),
      .word_o      (word),
      .stb_o       (upd_stb),
      .upper_o     (upd_upper)
   );

   // Decoded fields of the committed word
   assign octave  = word[WORD_W-1 -: OCT_W];
   assign fine    = word[CFG_W +: FINE_W];
   assign out_cfg = word[CFG_W-1:0];

   AST_IDLE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_n_s) |-> !upd_stb);  // R6

endmodule

// File: tb/sctl_port_bench.sv
`timescale 1ns/1ps
module sctl_port_bench;

   localparam int LAT = 3;  // two synchroniser stages plus commit register
   localparam int HP  = 4;  // serial half period in system cycles

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sen_n = 1'b1;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic [3:0] octave;
   logic [9:0] fine;
   logic [1:0] out_cfg;
   logic upd_stb;
   logic upd_upper;

   sctl_port u_sctl_port (
      .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk), .sdi(sdi),
      .octave(octave), .fine(fine), .out_cfg(out_cfg),
      .upd_stb(upd_stb), .upd_upper(upd_upper)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   string cur_tag = "R1";

   // Reference model
   logic [15:0] m_word = '0;
   logic [15:0] exp_word = '0;
   bit          exp_up = 1'b0;
   int          due_q[$];
   logic [15:0] val_q[$];
   bit          up_q[$];
   bit          m_active = 1'b0;
   int          m_cnt = 0;
   logic [7:0]  m_buf = '0;
   bit          run_cmp = 1'b0;
   int          stb_seen = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      bit es;
      es = 1'b0;
      if (run_cmp) begin
         if (due_q.size() > 0 && due_q[0] == cyc) begin
            exp_word = val_q.pop_front();
            exp_up   = up_q.pop_front();
            void'(due_q.pop_front());
            es = 1'b1;
         end
         chk({cur_tag, " word"}, {16'h0, octave, fine, out_cfg}, {16'h0, exp_word});
         chk("R5,R9 strobe", {31'h0, upd_stb}, {31'h0, es});
         if (es) chk("R3,R4 half flag", {31'h0, upd_upper}, {31'h0, exp_up});
         if (upd_stb) stb_seen++;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic model_rise(bit b);
      if (m_active && m_cnt < 16) begin
         m_buf = {m_buf[6:0], b};
         m_cnt++;
         if (m_cnt % 8 == 0) begin
            if (m_cnt == 8) m_word[15:8] = m_buf;
            else            m_word[7:0]  = m_buf;
            due_q.push_back(cyc + LAT);
            val_q.push_back(m_word);
            up_q.push_back(m_cnt == 8);
         end
      end
   endtask

   task automatic sbit(bit b);
      sdi = b;
      tick(HP);
      sclk = 1'b1;
      model_rise(b);
      tick(HP);
      sclk = 1'b0;
   endtask

   task automatic start_tx();
      sen_n = 1'b0;
      m_active = 1'b1;
      m_cnt = 0;
      tick(HP);
   endtask

   task automatic stop_tx();
      tick(HP);
      sen_n = 1'b1;
      m_active = 1'b0;
      tick(2 * HP);
   endtask

   task automatic send_bits(logic [31:0] w, int nbits);
      for (int i = 0; i < nbits; i++) sbit(w[nbits - 1 - i]);
   endtask

   task automatic frame(logic [31:0] w, int nbits);
      start_tx();
      send_bits(w, nbits);
      stop_tx();
   endtask

   task automatic chk_fields(string tag, logic [15:0] w);
      chk({tag, " octave"}, {28'h0, octave}, {28'h0, w[15:12]});
      chk({tag, " fine"},   {22'h0, fine},   {22'h0, w[11:2]});
      chk({tag, " cfg"},    {30'h0, out_cfg}, {30'h0, w[1:0]});
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
   end

   initial begin
      int s0;
      tick(3);
      chk_fields("R1 reset", 16'h0000);
      chk("R1 reset strobe", {31'h0, upd_stb}, 32'h0);
      rst_n = 1'b1;
      run_cmp = 1'b1;
      tick(4);
      chk_fields("R1 after release", 16'h0000);

      cur_tag = "R2";
      frame(32'hA5C3, 16);
      chk_fields("R2,R4 full frame", 16'hA5C3);

      cur_tag = "R3";
      frame(32'h003E, 8);
      chk_fields("R3 upper only", 16'h3EC3);

      cur_tag = "R6";
      for (int i = 0; i < 6; i++) sbit(i[0]);
      tick(2 * HP);
      chk_fields("R6 idle edges", 16'h3EC3);

      cur_tag = "R7";
      frame(32'h0015, 5);
      chk_fields("R7 partial discarded", 16'h3EC3);
      frame(32'h1234, 16);
      chk_fields("R7 restart at bit 15", 16'h1234);

      cur_tag = "R8";
      s0 = stb_seen;
      frame({12'h0, 16'h8001, 4'hF}, 20);
      chk_fields("R8 overrun", 16'h8001);
      chk("R8 strobe count", stb_seen - s0, 32'd2);

      cur_tag = "R2";
      frame(32'hFFFF, 16);
      chk_fields("R2 all ones", 16'hFFFF);
      frame(32'h0000, 16);
      chk_fields("R2 all zeros", 16'h0000);
      frame(32'h6DB6, 16);
      chk_fields("R2 mixed", 16'h6DB6);

      tick(4);
      run_cmp = 1'b0;
      summary();
      $finish;
   end

endmodule